// File: doc/BRIEF.md
# Streaming Mailbox Port with Auto-Incrementing Pointer

This block gives an 8-bit host processor a narrow window into a shared parameter buffer, which it uses to exchange bytes with a coprocessor. The host sets a buffer pointer with two writes to one register, high part first and low part second. It then streams bytes in through a write register or out through a read register. The pointer steps forward by one after every data access, so no address has to be decoded for each byte. The read path prefetches the byte under the pointer, so the host gets read data in the same cycle it asks for it.

A request for coprocessor work starts with a write of any value to the call register. The convention is that the host places a routine index at the start of a parameter block, followed by its input bytes (controller, switch and timer values) in a fixed order. The host then fires the call. The block raises a busy flag and sends a one-cycle call pulse to the coprocessor. While the flag is set the coprocessor owns the buffer: it reads and writes it through its own port, and every host data, pointer and call access is dropped. A done pulse from the coprocessor clears the flag. After that the host reads the results back through the streaming read register.

Top module: `mbx_port`

## Requirements
- R1: After reset the pointer is 0, the pointer byte selector expects the high part, busy is 0 and cp_call is 0.
- R2: Register 0 loads the pointer. The first write after the selector is reset sets pointer bits [PTR_W-1:8] from host_wdata[PTR_W-9:0]. The next write sets pointer bits [7:0] from host_wdata.
- R3: The pointer byte selector returns to "high part next" after a low-part write, after any accepted data write or data read, and after an accepted call write.
- R4: A write to register 1 stores host_wdata at the pointer address. On the next cycle the pointer is one higher.
- R5: A read of register 2 returns, in the same cycle, the byte at the pointer address, and then advances the pointer by one. Back-to-back reads therefore return consecutive bytes.
- R6: The pointer wraps from 2**PTR_W-1 to 0.
- R7: A write of any value to register 3 while idle sets busy on the next cycle. In that same cycle it raises cp_call for exactly one cycle.
- R8: A read of register 3 returns busy in bit 7 and zeros in bits 6:0.
- R9: While busy, writes to registers 0, 1 and 3 have no effect. Reads of register 2 return 0x00 and leave the pointer where it was.
- R10: cp_done while busy clears busy on the next cycle. cp_done while idle has no effect.
- R11: cp_rdata is the byte at cp_addr one cycle after cp_addr is presented. A cp_we write changes the buffer only while busy. A coprocessor write to the pointer address is visible to the host's next read, even when it arrives in the same cycle as cp_done.
- R12: Reads of registers 0 and 1 return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_cs | input | 1 | Host access strobe, one access per cycle |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_reg | input | 2 | Register select: 0 pointer, 1 data write, 2 data read, 3 call/status |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, combinational in the access cycle |
| busy | output | 1 | Coprocessor call pending |
| cp_call | output | 1 | One-cycle request to run the routine |
| cp_done | input | 1 | Coprocessor completion pulse |
| cp_addr | input | PTR_W | Coprocessor buffer address |
| cp_we | input | 1 | Coprocessor write enable |
| cp_wdata | input | 8 | Coprocessor write data |
| cp_rdata | output | 8 | Coprocessor read data, one cycle after cp_addr |

## Verification
The bench targets the pointer byte selector. It writes only the high part and then makes a data access. A design that failed to reset the selector would take the next pointer byte as a low part, and later reads would come from the wrong place.

It also checks that back-to-back reads stream consecutive bytes and that the pointer wraps at the top of the buffer. A prefetch that lagged by one cycle would return the same byte twice, and a pointer that did not wrap would read past the end of the buffer.

Host accesses are issued while a call is pending. A design that let them through would corrupt the parameter block or move the pointer. Finally, the coprocessor writes the byte under the pointer in the same cycle as its done pulse. Without the write-first bypass, the host's first read after the call would return the old byte.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    typedef enum logic [1:0] {
        REG_PTR   = 2'd0,
        REG_WDATA = 2'd1,
        REG_RDATA = 2'd2,
        REG_CALL  = 2'd3
    } mbx_reg_e;

    localparam int BYTE_W = 8;
endpackage

// File: rtl/mbx_ptr.sv
// Buffer pointer with two-write load and auto-increment
module mbx_ptr #(
    parameter int PTR_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_en,
    input  logic [7:0]       ld_data,
    input  logic             step,
    input  logic             sel_clr,
    output logic [PTR_W-1:0] ptr_q,
    output logic [PTR_W-1:0] ptr_d,
    output logic             hi_next_q
);
    localparam int HI_W = PTR_W - 8;
    localparam logic [PTR_W-1:0] ONE = PTR_W'(1);

    typedef struct packed {
        logic [PTR_W-1:0] ptr;
        logic             hi_next;
    } ptr_st_t;

    ptr_st_t s_q, s_d;

    always_comb begin
        s_d = s_q;
        if (ld_en) begin
            if (s_q.hi_next) begin
                s_d.ptr[PTR_W-1:8] = HI_W'(ld_data);
                s_d.hi_next        = 1'b0;
            end else begin
                s_d.ptr[7:0] = ld_data;
                s_d.hi_next  = 1'b1;
            end
        end else if (step) begin
            s_d.ptr     = s_q.ptr + ONE;
            s_d.hi_next = 1'b1;
        end
        if (sel_clr) begin
            s_d.hi_next = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.ptr     <= '0;
            s_q.hi_next <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign ptr_q     = s_q.ptr;
    assign ptr_d     = s_d.ptr;
    assign hi_next_q = s_q.hi_next;
endmodule

// File: rtl/mbx_call.sv
// Call strobe and busy tracking
module mbx_call (
    input  logic clk,
    input  logic rst_n,
    input  logic call_req,
    input  logic done,
    output logic busy_q,
    output logic call_q
);
    typedef struct packed {
        logic busy;
        logic call;
    } call_st_t;

    call_st_t s_q, s_d;

    always_comb begin
        s_d      = s_q;
        s_d.call = 1'b0;
        if (!s_q.busy && call_req) begin
            s_d.busy = 1'b1;
            s_d.call = 1'b1;
        end else if (s_q.busy && done) begin
            s_d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy_q = s_q.busy;
    assign call_q = s_q.call;
endmodule

// File: rtl/mbx_ram.sv
// Shared byte buffer: one write port, two registered read ports,
// port A write-first so a same-cycle write reaches the prefetch.
module mbx_ram #(
    parameter int PTR_W = 10
) (
    input  logic             clk,
    input  logic             we,
    input  logic [PTR_W-1:0] waddr,
    input  logic [7:0]       wdata,
    input  logic [PTR_W-1:0] ra_addr,
    output logic [7:0]       ra_q,
    input  logic [PTR_W-1:0] rb_addr,
    output logic [7:0]       rb_q
);
    localparam int DEPTH = 1 << PTR_W;

    logic [7:0] mem [DEPTH];
    logic [7:0] ra_d, rb_d;

    always_comb begin
        ra_d = mem[ra_addr];
        if (we && (waddr == ra_addr)) begin
            ra_d = wdata;
        end
        rb_d = mem[rb_addr];
    end

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        ra_q <= ra_d;
        rb_q <= rb_d;
    end
endmodule

// File: rtl/mbx_port.sv
// Streaming mailbox port: host register decode and datapath
module mbx_port #(
    parameter int PTR_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_cs,
    input  logic             host_wr,
    input  logic [1:0]       host_reg,
    input  logic [7:0]       host_wdata,
    output logic [7:0]       host_rdata,
    output logic             busy,
    output logic             cp_call,
    input  logic             cp_done,
    input  logic [PTR_W-1:0] cp_addr,
    input  logic             cp_we,
    input  logic [7:0]       cp_wdata,
    output logic [7:0]       cp_rdata
);
    import mbx_pkg::*;

    mbx_reg_e         reg_sel;
    logic             acc;
    logic             wr_ptr, wr_dat, rd_dat, wr_call;
    logic             busy_q;
    logic [PTR_W-1:0] ptr_q, ptr_d;
    logic             hi_next_q;
    logic             mem_we;
    logic [PTR_W-1:0] mem_waddr;
    logic [7:0]       mem_wdata;
    logic [7:0]       pf_q;

    always_comb begin
        reg_sel = mbx_reg_e'(host_reg);
        acc     = host_cs && !busy_q;
        wr_ptr  = acc && host_wr  && (reg_sel == REG_PTR);
        wr_dat  = acc && host_wr  && (reg_sel == REG_WDATA);
        rd_dat  = acc && !host_wr && (reg_sel == REG_RDATA);
        wr_call = acc && host_wr  && (reg_sel == REG_CALL);
    end

    mbx_ptr #(.PTR_W(PTR_W)) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld_en     (wr_ptr),
        .ld_data   (host_wdata),
        .step      (wr_dat || rd_dat),
        .sel_clr   (wr_dat || rd_dat || wr_call),
        .ptr_q     (ptr_q),
        .ptr_d     (ptr_d),
        .hi_next_q (hi_next_q)
    );

    mbx_call u_call (
        .clk      (clk),
        .rst_n    (rst_n),
        .call_req (wr_call),
        .done     (cp_done),
        .busy_q   (busy_q),
        .call_q   (cp_call)
    );

    // host owns the write port when idle, coprocessor when busy
    always_comb begin
        if (wr_dat) begin
            mem_we    = 1'b1;
            mem_waddr = ptr_q;
            mem_wdata = host_wdata;
        end else begin
            mem_we    = cp_we && busy_q;
            mem_waddr = cp_addr;
            mem_wdata = cp_wdata;
        end
    end

    mbx_ram #(.PTR_W(PTR_W)) u_ram (
        .clk     (clk),
        .we      (mem_we),
        .waddr   (mem_waddr),
        .wdata   (mem_wdata),
        .ra_addr (ptr_d),
        .ra_q    (pf_q),
        .rb_addr (cp_addr),
        .rb_q    (cp_rdata)
    );

    always_comb begin
        host_rdata = 8'h00;
        if (host_cs && !host_wr) begin
            case (reg_sel)
                REG_RDATA: host_rdata = busy_q ? 8'h00 : pf_q;
                REG_CALL:  host_rdata = {busy_q, 7'b0};
                default:   host_rdata = 8'h00;
            endcase
        end
    end

    assign busy = busy_q;
endmodule

// File: rtl/mbx_port_chk.sv
module mbx_port_chk #(
    parameter int PTR_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             host_cs,
    input logic             host_wr,
    input logic [1:0]       host_reg,
    input logic             busy,
    input logic             cp_call,
    input logic             cp_done,
    input logic [PTR_W-1:0] ptr,
    input logic             hi_next
);
    logic call_wr, data_wr, data_rd;
    assign call_wr = host_cs && host_wr  && (host_reg == 2'd3) && !busy;
    assign data_wr = host_cs && host_wr  && (host_reg == 2'd1) && !busy;
    assign data_rd = host_cs && !host_wr && (host_reg == 2'd2) && !busy;

    p_call_sets_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        call_wr |=> (busy && cp_call));
    p_call_one_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cp_call |=> !cp_call);
    p_done_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cp_done) |=> !busy);
    p_idle_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !call_wr) |=> !busy);
    p_ptr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(ptr));
    p_wr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        data_wr |=> (ptr == PTR_W'($past(ptr) + 1)));
    p_rd_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        data_rd |=> (ptr == PTR_W'($past(ptr) + 1)));
    p_sel_reset_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr || data_rd || call_wr) |=> hi_next);
endmodule

bind mbx_port mbx_port_chk #(.PTR_W(PTR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .host_cs  (host_cs),
    .host_wr  (host_wr),
    .host_reg (host_reg),
    .busy     (busy),
    .cp_call  (cp_call),
    .cp_done  (cp_done),
    .ptr      (ptr_q),
    .hi_next  (hi_next_q)
);

// File: tb/test_mbx_port.sv
`timescale 1ns/1ps
module test_mbx_port;
    localparam int PTR_W = 10;
    localparam int DEPTH = 1 << PTR_W;
    localparam int HI_MASK = (1 << (PTR_W - 8)) - 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             host_cs = 1'b0, host_wr = 1'b0;
    logic [1:0]       host_reg = 2'd0;
    logic [7:0]       host_wdata = 8'h00;
    logic [7:0]       host_rdata;
    logic             busy, cp_call;
    logic             cp_done = 1'b0, cp_we = 1'b0;
    logic [PTR_W-1:0] cp_addr = '0;
    logic [7:0]       cp_wdata = 8'h00, cp_rdata;

    always #2 clk = ~clk;

    mbx_port #(.PTR_W(PTR_W)) i_mbx_port (
        .clk(clk), .rst_n(rst_n), .host_cs(host_cs), .host_wr(host_wr),
        .host_reg(host_reg), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .busy(busy), .cp_call(cp_call), .cp_done(cp_done), .cp_addr(cp_addr),
        .cp_we(cp_we), .cp_wdata(cp_wdata), .cp_rdata(cp_rdata)
    );

    int  n_chk = 0, n_fail = 0;
    logic [7:0] mdl [DEPTH];
    int  mptr = 0;
    bit  mhi = 1'b1, mbusy = 1'b0;

    task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_rdata(input logic [1:0] r);
        case (r)
            2'd2:    return mbusy ? 8'h00 : mdl[mptr];
            2'd3:    return {mbusy, 7'b0};
            default: return 8'h00;
        endcase
    endfunction

    task automatic op(input logic [1:0] r, input bit wr, input logic [7:0] d, input string tag);
        logic [7:0] e;
        bit call_exp;
        @(negedge clk);
        host_cs = 1'b1; host_wr = wr; host_reg = r; host_wdata = d;
        #1;
        if (!wr) begin
            e = exp_rdata(r);
            chk(host_rdata === e, tag, {8'h0, host_rdata}, {8'h0, e});
        end
        @(posedge clk); #1;
        host_cs = 1'b0;
        call_exp = 1'b0;
        if (!mbusy) begin
            case (r)
                2'd0: if (wr) begin
                    if (mhi) mptr = ((int'(d) & HI_MASK) << 8) | (mptr & 255);
                    else     mptr = (mptr & ~255) | int'(d);
                    mhi = !mhi;
                end
                2'd1: if (wr) begin mdl[mptr] = d; mptr = (mptr + 1) % DEPTH; mhi = 1'b1; end
                2'd2: if (!wr) begin mptr = (mptr + 1) % DEPTH; mhi = 1'b1; end
                default: if (wr) begin mbusy = 1'b1; mhi = 1'b1; call_exp = 1'b1; end
            endcase
        end
        chk(busy === mbusy, "R9 busy after host access", {15'h0, busy}, {15'h0, mbusy});
        chk(cp_call === call_exp, "R7 call pulse", {15'h0, cp_call}, {15'h0, call_exp});
    endtask

    task automatic set_ptr(input int a, input string tag);
        op(2'd0, 1'b1, 8'(a >> 8), tag);
        op(2'd0, 1'b1, 8'(a & 255), tag);
    endtask

    task automatic cp_cycle(input bit we, input int a, input logic [7:0] d, input bit done, input string tag);
        @(negedge clk);
        cp_we = we; cp_addr = PTR_W'(a); cp_wdata = d; cp_done = done;
        @(posedge clk); #1;
        cp_we = 1'b0; cp_done = 1'b0;
        if (we && mbusy) mdl[a] = d;
        if (done && mbusy) mbusy = 1'b0;
        chk(busy === mbusy, tag, {15'h0, busy}, {15'h0, mbusy});
        chk(cp_call === 1'b0, "R7 call pulse ends", {15'h0, cp_call}, 16'h0);
    endtask

    task automatic cp_rd(input int a, input string tag);
        @(negedge clk);
        cp_addr = PTR_W'(a);
        @(posedge clk); #1;
        chk(cp_rdata === mdl[a], tag, {8'h0, cp_rdata}, {8'h0, mdl[a]});
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        int unsigned seed;
        seed = $urandom(32'd20240611);
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        chk(busy === 1'b0, "R1 busy at reset", {15'h0, busy}, 16'h0);
        chk(cp_call === 1'b0, "R1 call at reset", {15'h0, cp_call}, 16'h0);
        op(2'd3, 1'b0, 8'h00, "R8 status idle");
        op(2'd0, 1'b0, 8'h00, "R12 reg0 read");
        op(2'd1, 1'b0, 8'h00, "R12 reg1 read");
        op(2'd1, 1'b1, 8'hA5, "R1 write at reset pointer");
        set_ptr(0, "R2");
        op(2'd2, 1'b0, 8'h00, "R1 pointer was zero");

        // fill the whole buffer; pointer wraps back to 0
        set_ptr(0, "R2");
        for (int i = 0; i < DEPTH; i++) op(2'd1, 1'b1, 8'($urandom), "R4 fill");
        op(2'd2, 1'b0, 8'h00, "R6 wrap after fill");
        set_ptr(DEPTH - 1, "R2");
        op(2'd2, 1'b0, 8'h00, "R6 top byte");
        op(2'd2, 1'b0, 8'h00, "R6 wrapped read");

        // two-write load and streaming
        set_ptr(12'h2AB, "R2");
        op(2'd1, 1'b1, 8'h11, "R4");
        op(2'd1, 1'b1, 8'h22, "R4");
        set_ptr(12'h2AB, "R2");
        op(2'd2, 1'b0, 8'h00, "R5 first");
        op(2'd2, 1'b0, 8'h00, "R5 second");
        op(2'd2, 1'b0, 8'h00, "R5 third");

        // selector reset by a data access after a lone high write
        set_ptr(12'h050, "R2");
        op(2'd1, 1'b1, 8'h5A, "R4");
        set_ptr(12'h100, "R2");
        op(2'd0, 1'b1, 8'h03, "R3 lone high");
        op(2'd1, 1'b1, 8'h77, "R3 data write");
        op(2'd0, 1'b1, 8'h00, "R3 high again");
        op(2'd0, 1'b1, 8'h50, "R3 low");
        op(2'd2, 1'b0, 8'h00, "R3 read marker");
        set_ptr(12'h300, "R2");
        op(2'd2, 1'b0, 8'h00, "R3 byte at 0x300");

        // call sequence
        set_ptr(12'h040, "R2");
        op(2'd1, 1'b1, 8'h02, "R4 routine index");
        op(2'd1, 1'b1, 8'h11, "R4 input a");
        op(2'd1, 1'b1, 8'h22, "R4 input b");
        op(2'd1, 1'b1, 8'h33, "R4 input c");
        op(2'd3, 1'b1, 8'h5C, "R7 call");
        op(2'd3, 1'b0, 8'h00, "R8 status busy");
        cp_rd(12'h040, "R11 coprocessor reads index");
        cp_rd(12'h043, "R11 coprocessor reads input");
        op(2'd1, 1'b1, 8'hEE, "R9 write while busy");
        op(2'd0, 1'b1, 8'h01, "R9 pointer write while busy");
        op(2'd2, 1'b0, 8'h00, "R9 read while busy");
        op(2'd3, 1'b1, 8'h00, "R9 call while busy");
        cp_cycle(1'b1, 12'h045, 8'hC3, 1'b0, "R11 result write");
        cp_cycle(1'b1, 12'h044, 8'h9C, 1'b1, "R10 done with write");
        op(2'd2, 1'b0, 8'h00, "R11 bypassed result");
        op(2'd2, 1'b0, 8'h00, "R11 second result");
        cp_cycle(1'b1, 12'h046, 8'hFF, 1'b0, "R11 idle write");
        cp_cycle(1'b0, 12'h000, 8'h00, 1'b1, "R10 idle done");
        op(2'd2, 1'b0, 8'h00, "R11 idle write ignored");
        op(2'd3, 1'b0, 8'h00, "R10 status after idle done");

        // random mix
        for (int i = 0; i < 600; i++) begin
            int unsigned k;
            k = $urandom % 9;
            case (k)
                0: set_ptr(int'($urandom % DEPTH), "R2 random load");
                1: op(2'd0, 1'b1, 8'($urandom), "R3 random single");
                2, 3: op(2'd1, 1'b1, 8'($urandom), "R4 random write");
                4, 5: op(2'd2, 1'b0, 8'h00, "R5 random read");
                6: op(2'($urandom), 1'b0, 8'h00, "R8 random read");
                7: if (!mbusy) op(2'd3, 1'b1, 8'($urandom), "R7 random call");
                   else cp_rd(int'($urandom % DEPTH), "R11 random cp read");
                default: cp_cycle(1'($urandom), int'($urandom % DEPTH), 8'($urandom),
                                  1'($urandom), "R10 random coprocessor");
            endcase
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule